// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Overflow Trap

This unit adds or subtracts two 32-bit tagged integers. A tagged integer keeps a two-bit type tag in its least significant bits, and a valid operand has a tag of zero. When an operation is requested, the unit computes the wrapped 32-bit sum or difference. It raises a one-cycle trap strobe if either operand carries a nonzero tag, or if the signed operation overflows.

Beside the result, the unit keeps a small register set that later condition-code logic reads: the first operand, the second operand, the result and a code naming the operation. This set is written only by an operation that completes without a trap. A trapping operation therefore leaves the flag inputs exactly as the last successful operation left them.

All outputs are registered. A request sampled at one rising edge is reflected on the outputs from that edge onward.

Top module: `tagged_arith_unit`

## Requirements
- R1: While reset is asserted and after its release, before any request: `res_valid` and `trap` are 0, `flg_src1`, `flg_src2` and `flg_dst` are 0, and `flg_op` is 2'b00 (no operation recorded).
- R2: An add request (`op_sub`=0, `in_valid`=1) with zero tags and no overflow gives `res_out` = (a + b) mod 2^32, `res_valid`=1 and `trap`=0 in the cycle after the sampling edge.
- R3: A subtract request (`op_sub`=1) with zero tags and no overflow gives `res_out` = (a - b) mod 2^32, `res_valid`=1 and `trap`=0 in the cycle after the sampling edge.
- R4: If bit 0 or bit 1 of either operand is 1, `trap` is 1 and `res_valid` is 0 in the cycle after the sampling edge, for both add and subtract.
- R5: An add traps when both operands have the same bit 31 and the sum's bit 31 differs from it (signed overflow).
- R6: A subtract traps when the operands' bit 31 differ and the difference's bit 31 differs from that of the first operand (signed overflow).
- R7: A non-trapping request sets `flg_src1`=a, `flg_src2`=b, `flg_dst`=result, and `flg_op`=2'b01 for add or 2'b10 for subtract.
- R8: A trapping request leaves `flg_src1`, `flg_src2`, `flg_dst` and `flg_op` unchanged.
- R9: `trap` and `res_valid` are never 1 in the same cycle.
- R10: In a cycle after an edge where `in_valid` was 0, `trap` and `res_valid` are 0, and `res_out` and all flag registers keep their values.
- R11: On a trap, `res_out` still carries the wrapped 32-bit sum or difference of the trapping request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, sampled each edge |
| op_sub | input | 1 | 0 = tagged add, 1 = tagged subtract |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_out | output | 32 | Wrapped result of the last request |
| res_valid | output | 1 | Last request completed without trap |
| trap | output | 1 | Last request raised a tag-overflow trap |
| flg_src1 | output | 32 | Saved first operand for flag logic |
| flg_src2 | output | 32 | Saved second operand for flag logic |
| flg_dst | output | 32 | Saved result for flag logic |
| flg_op | output | 2 | Saved operation code: 00 none, 01 add, 10 subtract |

## Verification
Two functions are decided by the same request in the same cycle: raising the trap and writing the flag registers. The bench drives requests in which a tag error and arithmetic overflow occur together, and requests that hit only one of the two, and interleaves them with clean ones. After every trap it compares all four flag registers with the values left by the previous clean request. It also checks that `trap` and `res_valid` never rise together.

// File: rtl/tagged_arith_pkg.sv
package tagged_arith_pkg;

    localparam int unsigned OPND_W = 32;
    localparam int unsigned TAG_BITS = 2;

    typedef enum logic [1:0] {
        FOP_NONE = 2'b00,
        FOP_TADD = 2'b01,
        FOP_TSUB = 2'b10
    } flag_op_e;

endpackage

// File: rtl/tag_check.sv
module tag_check #(
    parameter int unsigned TAG_W = 2
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             tag_bad
);

    logic [TAG_W-1:0] tag_or;

    always_comb begin
        tag_or  = tag_a | tag_b;
        tag_bad = |tag_or;
    end

endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);

    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] dif_w;
    logic              sum_ovf;
    logic              dif_ovf;

    always_comb begin
        sum_w   = src_a + src_b;
        dif_w   = src_a - src_b;
        // same-sign inputs, sign of the sum flipped
        sum_ovf = (src_a[MSB] == src_b[MSB]) && (sum_w[MSB] != src_a[MSB]);
        // opposite-sign inputs, sign of the difference flipped from minuend
        dif_ovf = (src_a[MSB] != src_b[MSB]) && (dif_w[MSB] != src_a[MSB]);
        result  = do_sub ? dif_w : sum_w;
        ovf     = do_sub ? dif_ovf : sum_ovf;
    end

endmodule

// File: rtl/flag_state_reg.sv
module flag_state_reg
    import tagged_arith_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sub,
    input  logic [DATA_W-1:0] wr_src1,
    input  logic [DATA_W-1:0] wr_src2,
    input  logic [DATA_W-1:0] wr_dst,
    output logic [DATA_W-1:0] src1,
    output logic [DATA_W-1:0] src2,
    output logic [DATA_W-1:0] dst,
    output flag_op_e          op
);

    typedef struct packed {
        logic [DATA_W-1:0] s1;
        logic [DATA_W-1:0] s2;
        logic [DATA_W-1:0] d;
        flag_op_e          op;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.s1 = wr_src1;
            st_d.s2 = wr_src2;
            st_d.d  = wr_dst;
            st_d.op = wr_sub ? FOP_TSUB : FOP_TADD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{s1: '0, s2: '0, d: '0, op: FOP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign src1 = st_q.s1;
    assign src2 = st_q.s2;
    assign dst  = st_q.d;
    assign op   = st_q.op;

    // R8 / R10: without a write the saved state must not move
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(src1) && $stable(src2) && $stable(dst) && $stable(op)));

    // R7: a write records the operands and a real operation code
    p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (src1 == $past(wr_src1) && src2 == $past(wr_src2) && op != FOP_NONE));

endmodule

// File: rtl/tagged_arith_unit.sv
module tagged_arith_unit
    import tagged_arith_pkg::*;
#(
    parameter int unsigned DATA_W = OPND_W,
    parameter int unsigned TAG_W  = TAG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_out,
    output logic              res_valid,
    output logic              trap,
    output logic [DATA_W-1:0] flg_src1,
    output logic [DATA_W-1:0] flg_src2,
    output logic [DATA_W-1:0] flg_dst,
    output logic [1:0]        flg_op
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ok;
        logic              trp;
    } out_st_t;

    logic [DATA_W-1:0] alu_res;
    logic              alu_ovf;
    logic              tag_bad;
    logic              trap_now;
    logic              commit;
    flag_op_e          fop;

    out_st_t out_d, out_q;

    tag_check #(.TAG_W(TAG_W)) u_tag (
        .tag_a   (opnd_a[TAG_W-1:0]),
        .tag_b   (opnd_b[TAG_W-1:0]),
        .tag_bad (tag_bad)
    );

    addsub_ovf #(.DATA_W(DATA_W)) u_alu (
        .src_a  (opnd_a),
        .src_b  (opnd_b),
        .do_sub (op_sub),
        .result (alu_res),
        .ovf    (alu_ovf)
    );

    always_comb begin
        trap_now = in_valid && (tag_bad || alu_ovf);
        commit   = in_valid && !(tag_bad || alu_ovf);
        out_d    = out_q;
        out_d.ok  = 1'b0;
        out_d.trp = 1'b0;
        if (in_valid) begin
            out_d.res = alu_res;
            out_d.ok  = commit;
            out_d.trp = trap_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    flag_state_reg #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_sub  (op_sub),
        .wr_src1 (opnd_a),
        .wr_src2 (opnd_b),
        .wr_dst  (alu_res),
        .src1    (flg_src1),
        .src2    (flg_src2),
        .dst     (flg_dst),
        .op      (fop)
    );

    assign flg_op    = fop;
    assign res_out   = out_q.res;
    assign res_valid = out_q.ok;
    assign trap      = out_q.trp;

    // R9: trap and successful completion are exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && res_valid));

    // R10: an idle edge leaves no strobe behind
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!trap && !res_valid && $stable(res_out)));

    // R4: any nonzero tag bit on a request must trap
    p_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((opnd_a[TAG_W-1:0] | opnd_b[TAG_W-1:0]) != '0)) |=> trap);

    // R7: a clean completion is mirrored into the saved result
    p_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flg_dst == res_out));

endmodule

// File: tb/tagged_arith_unit_test.sv
`timescale 1ns/1ps
module tagged_arith_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] res_out;
    logic        res_valid;
    logic        trap;
    logic [31:0] flg_src1;
    logic [31:0] flg_src2;
    logic [31:0] flg_dst;
    logic [1:0]  flg_op;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_s1 = '0;
    logic [31:0] m_s2 = '0;
    logic [31:0] m_d  = '0;
    logic [1:0]  m_op = 2'b00;
    logic [31:0] m_res = '0;

    always #10 clk = ~clk;

    tagged_arith_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_out(res_out),
        .res_valid(res_valid), .trap(trap), .flg_src1(flg_src1),
        .flg_src2(flg_src2), .flg_dst(flg_dst), .flg_op(flg_op)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(flg_src1 == m_s1, req, flg_src1, m_s1);
        chk(flg_src2 == m_s2, req, flg_src2, m_s2);
        chk(flg_dst  == m_d,  req, flg_dst,  m_d);
        chk(flg_op   == m_op, req, {30'd0, flg_op}, {30'd0, m_op});
    endtask

    // one request; returns after the output cycle is settled
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit sub,
                         input string req);
        logic [31:0] r;
        bit ovf;
        bit tg;
        bit exp_trap;
        r   = sub ? a - b : a + b;
        tg  = ((a | b) & 32'h3) != 0;
        if (sub) ovf = (a[31] != b[31]) && (r[31] != a[31]);
        else     ovf = (a[31] == b[31]) && (r[31] != a[31]);
        exp_trap = tg || ovf;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        m_res = r;
        if (!exp_trap) begin
            m_s1 = a; m_s2 = b; m_d = r; m_op = sub ? 2'b10 : 2'b01;
        end
        chk(trap == exp_trap, {req, " trap"}, {31'd0, trap}, {31'd0, exp_trap});
        chk(res_valid == !exp_trap, {req, " res_valid"}, {31'd0, res_valid},
            {31'd0, !exp_trap});
        chk(res_out == r, {req, " res_out R11"}, res_out, r);
        chk(!(trap && res_valid), "R9 exclusive", {30'd0, trap, res_valid}, 32'd0);
        chk_flags(exp_trap ? "R8 flags held" : "R7 flags written");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!res_valid && !trap, "R1 strobes", {30'd0, trap, res_valid}, 32'd0);
        chk_flags("R1 flags");
        rst_n = 1'b1;
        @(negedge clk);
        chk(!res_valid && !trap, "R1 after release", {30'd0, trap, res_valid}, 32'd0);
        chk_flags("R1 flags after release");
    endtask

    task automatic t_add();
        issue(32'h0000_0004, 32'h0000_0008, 1'b0, "R2 small add");
        issue(32'hFFFF_FFFC, 32'h0000_0008, 1'b0, "R2 neg plus pos");
        issue(32'h8000_0000, 32'h7FFF_FFFC, 1'b0, "R2 mixed sign");
    endtask

    task automatic t_sub();
        issue(32'h0000_0010, 32'h0000_0004, 1'b1, "R3 small sub");
        issue(32'h0000_0004, 32'h0000_0010, 1'b1, "R3 negative diff");
        issue(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 equal min");
    endtask

    task automatic t_tag();
        issue(32'h0000_0101, 32'h0000_0004, 1'b0, "R4 a bit0 add");
        issue(32'h0000_0004, 32'h0000_0002, 1'b0, "R4 b bit1 add");
        issue(32'h0000_0013, 32'h0000_0003, 1'b1, "R4 both tags sub");
        issue(32'h0000_0020, 32'h0000_0008, 1'b1, "R3 clean after tag traps");
    endtask

    task automatic t_ovf();
        issue(32'h7FFF_FFFC, 32'h0000_0004, 1'b0, "R5 pos overflow add");
        issue(32'h8000_0000, 32'h8000_0000, 1'b0, "R5 neg overflow add");
        issue(32'h7FFF_FFFC, 32'h0000_0004, 1'b0, "R5 repeat after trap");
        issue(32'h8000_0000, 32'h0000_0004, 1'b1, "R6 neg minus pos");
        issue(32'h7FFF_FFFC, 32'hFFFF_FFFC, 1'b1, "R6 pos minus neg");
        issue(32'h7FFF_FFFD, 32'h0000_0004, 1'b0, "R4 R5 tag and overflow");
        issue(32'h7FFF_FFF8, 32'h0000_0004, 1'b0, "R2 near max no ovf");
    endtask

    task automatic t_idle();
        logic [31:0] keep;
        keep = res_out;
        @(negedge clk);
        opnd_a = 32'h0000_0001; opnd_b = 32'h7FFF_FFFF; op_sub = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!trap && !res_valid, "R10 idle strobes", {30'd0, trap, res_valid}, 32'd0);
        chk(res_out == keep, "R10 idle result held", res_out, keep);
        chk_flags("R10 idle flags held");
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_tag();
        t_ovf();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule